// File: doc/BRIEF.md
# DAC Load Termination Check Sequencer

This block decides when the six video DAC outputs are tested for a correctly terminated load, runs each test and keeps the results. A test drives a sense strobe to the analog comparators for a fixed window. On the last cycle of that window it samples the six comparator outputs. Each comparator reports whether its DAC sees the combined load of a double-terminated line. The sampled results are gated by the per-DAC enables and stored as six status bits.

Tests start in one of two ways. In automatic mode a test starts on every frame-start strobe that arrives while the block is idle. In manual mode software writes a one-shot trigger bit, which the hardware clears as soon as the test begins. A small register port gives access to the control bits and the status bits. Read data is registered.

Top module: `load_detect_ctrl`

## Requirements
- R1: After reset the auto bit, the trigger bit and all six status bits are 0, `sense_strobe` is low and `reg_rdata` is 0.
- R2: Address 0 is the control register: bit 0 is the auto-check enable and bit 1 is the check trigger. A write to address 0 loads bit 0, and a read of address 0 returns {6'b0, trigger, auto}.
- R3: While the auto bit is 1 and no check is running, a `frame_start` pulse starts a check, and `sense_strobe` is high from the next clock edge.
- R4: While the auto bit is 0, `frame_start` has no effect. A write to address 0 with bit 1 = 1 and bit 0 = 0, made while idle, starts exactly one check.
- R5: The trigger bit reads 1 only until its check starts. It clears on the same edge that raises `sense_strobe`.
- R6: `sense_strobe` stays high for exactly 4 consecutive cycles per check.
- R7: On the edge that ends the strobe window, status bit k (DAC k, A=0 to F=5) is loaded from `cmp_match[k] & dac_en[k]`, sampled on the last strobe cycle. A read of address 1 returns DAC A in bit 2 through DAC F in bit 7.
- R8: A DAC whose enable is low on the sampling cycle reports 0 in its status bit.
- R9: A trigger write or a `frame_start` pulse that arrives while a check is running is absorbed: no second check follows, and the trigger bit stays 0.
- R10: Status bits keep their values between checks, comparator changes outside the sampling cycle do not affect them, writes to address 1 are ignored, and bits 1:0 of address 1 read as 0.
- R11: `reg_rdata` reflects the addressed register one cycle after the address is presented. Addresses other than 0 and 1 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| frame_start | input | 1 | One-cycle start-of-frame strobe |
| dac_en | input | 6 | Per-DAC output enable, bit 0 = DAC A |
| cmp_match | input | 6 | Per-DAC comparator result, 1 = double-terminated load |
| sense_strobe | output | 1 | Sense request to the analog comparators |

## Verification
A trigger or `frame_start` seen at edge s raises `sense_strobe` after edge s. The strobe falls after edge s+4. The status is loaded at edge s+4 and can be seen on `reg_rdata` after edge s+5, provided address 1 is held. The trigger bit appears on a read of address 0 one edge after the write. The bench drives inputs on the falling edge and advances its behavioural model on the rising edge. It compares `sense_strobe` and `reg_rdata` against the model on the next falling edge, so every one of these delays is checked on every cycle, not only at chosen points.

// File: rtl/ld_pkg.sv
package ld_pkg;
  localparam int CTRL_ADDR = 0;
  localparam int STAT_ADDR = 1;
  localparam int AUTO_BIT  = 0;
  localparam int TRIG_BIT  = 1;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_SENSE = 1'b1
  } seq_state_t;
endpackage

// File: rtl/ld_regs.sv
module ld_regs
  import ld_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 8,
  parameter int NUM_DAC  = 6,
  parameter int STAT_LSB = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [NUM_DAC-1:0] status,
  input  logic              busy,
  input  logic              start,
  output logic              auto_en,
  output logic              trig_req,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic              ctrl_wr;
  logic              trig_set;
  logic [DATA_W-1:0] rd_next;

  assign ctrl_wr  = reg_wr && (reg_addr == CTRL_A);
  // A trigger is accepted only in manual mode and only when idle.
  assign trig_set = ctrl_wr && reg_wdata[TRIG_BIT] && !reg_wdata[AUTO_BIT] && !busy;

  always_comb begin
    rd_next = '0;
    if (reg_addr == CTRL_A) begin
      rd_next[AUTO_BIT] = auto_en;
      rd_next[TRIG_BIT] = trig_req;
    end else if (reg_addr == STAT_A) begin
      rd_next[STAT_LSB +: NUM_DAC] = status;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      auto_en   <= 1'b0;
      trig_req  <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (ctrl_wr) auto_en <= reg_wdata[AUTO_BIT];
      if (trig_set)   trig_req <= 1'b1;
      else if (start) trig_req <= 1'b0;
      reg_rdata <= rd_next;
    end
  end

  AST_TRIG_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (trig_req && start && !trig_set) |=> !trig_req); // R5
  AST_TRIG_ABSORBED: assert property (@(posedge clk) disable iff (rst)
    (busy && !trig_req) |=> !trig_req); // R9
  AST_STAT_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr) == STAT_A && !$past(rst)) |-> reg_rdata[STAT_LSB-1:0] == '0); // R10
endmodule

// File: rtl/ld_sequencer.sv
module ld_sequencer
  import ld_pkg::*;
#(
  parameter int SENSE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic auto_en,
  input  logic trig_req,
  input  logic frame_start,
  output logic start,
  output logic sense_strobe,
  output logic sample_pulse
);
  localparam int CNT_W = (SENSE_CYCLES > 1) ? $clog2(SENSE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SENSE_CYCLES - 1);

  seq_state_t       state, state_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;

  assign start        = (state == SEQ_IDLE) && ((auto_en && frame_start) || trig_req);
  assign sample_pulse = (state == SEQ_SENSE) && (cnt == LAST);

  always_comb begin
    state_nx = state;
    cnt_nx   = cnt;
    case (state)
      SEQ_IDLE: begin
        cnt_nx = '0;
        if (start) state_nx = SEQ_SENSE;
      end
      SEQ_SENSE: begin
        if (cnt == LAST) begin
          state_nx = SEQ_IDLE;
          cnt_nx   = '0;
        end else begin
          cnt_nx = cnt + 1'b1;
        end
      end
      default: state_nx = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= SEQ_IDLE;
      cnt          <= '0;
      sense_strobe <= 1'b0;
    end else begin
      state        <= state_nx;
      cnt          <= cnt_nx;
      sense_strobe <= (state_nx == SEQ_SENSE);
    end
  end

  AST_STROBE_ENDS: assert property (@(posedge clk) disable iff (rst)
    (sense_strobe && cnt == LAST) |=> !sense_strobe); // R6
  AST_STROBE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (sense_strobe && cnt != LAST) |=> sense_strobe); // R6
  AST_AUTO_START: assert property (@(posedge clk) disable iff (rst)
    (!sense_strobe && auto_en && frame_start) |=> sense_strobe); // R3
  AST_NO_SPURIOUS_START: assert property (@(posedge clk) disable iff (rst)
    (!sense_strobe && !auto_en && !trig_req) |=> !sense_strobe); // R4
endmodule

// File: rtl/ld_capture.sv
module ld_capture #(
  parameter int NUM_DAC = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sample_pulse,
  input  logic [NUM_DAC-1:0] dac_en,
  input  logic [NUM_DAC-1:0] cmp_match,
  output logic [NUM_DAC-1:0] status
);
  for (genvar k = 0; k < NUM_DAC; k++) begin : g_dac
    always_ff @(posedge clk) begin
      if (rst)               status[k] <= 1'b0;
      else if (sample_pulse) status[k] <= cmp_match[k] & dac_en[k];
    end
  end

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sample_pulse |=> $stable(status)); // R10
  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (rst)
    sample_pulse |=> ((status & ~$past(dac_en)) == '0)); // R8
endmodule

// File: rtl/load_detect_ctrl.sv
module load_detect_ctrl #(
  parameter int ADDR_W       = 2,
  parameter int DATA_W       = 8,
  parameter int NUM_DAC      = 6,
  parameter int STAT_LSB     = 2,
  parameter int SENSE_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               frame_start,
  input  logic [NUM_DAC-1:0] dac_en,
  input  logic [NUM_DAC-1:0] cmp_match,
  output logic               sense_strobe
);
  logic               auto_en;
  logic               trig_req;
  logic               start;
  logic               sample_pulse;
  logic [NUM_DAC-1:0] status;

  ld_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_DAC(NUM_DAC), .STAT_LSB(STAT_LSB)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .status(status), .busy(sense_strobe),
    .start(start), .auto_en(auto_en), .trig_req(trig_req),
    .reg_rdata(reg_rdata)
  );

  ld_sequencer #(.SENSE_CYCLES(SENSE_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .auto_en(auto_en), .trig_req(trig_req),
    .frame_start(frame_start), .start(start), .sense_strobe(sense_strobe),
    .sample_pulse(sample_pulse)
  );

  ld_capture #(.NUM_DAC(NUM_DAC)) u_cap (
    .clk(clk), .rst(rst), .sample_pulse(sample_pulse), .dac_en(dac_en),
    .cmp_match(cmp_match), .status(status)
  );

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(sense_strobe) |-> $past(start)); // R3
  AST_SAMPLE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    sample_pulse |-> sense_strobe); // R7
endmodule

// File: tb/tb_load_detect_ctrl.sv
module tb_load_detect_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SENSE      = 4;

  logic       clk = 1'b0;
  logic       rst;
  logic       reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       frame_start;
  logic [5:0] dac_en;
  logic [5:0] cmp_match;
  logic       sense_strobe;

  int    n_checks = 0;
  int    n_errors = 0;
  string phase    = "R1";

  // behavioural model state
  bit       m_auto, m_trig, m_strobe;
  int       m_cnt;
  bit [5:0] m_status;
  bit [7:0] m_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  load_detect_ctrl dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
    .dac_en(dac_en), .cmp_match(cmp_match), .sense_strobe(sense_strobe)
  );

  task automatic model_edge();
    bit busy, start, tset;
    bit [7:0] rd;
    if (rst) begin
      m_auto = 0; m_trig = 0; m_cnt = -1; m_status = '0; m_rdata = '0; m_strobe = 0;
      return;
    end
    busy  = (m_cnt >= 0);
    rd    = 8'h00;
    if (reg_addr == 2'd0) rd = {6'b0, m_trig, m_auto};
    else if (reg_addr == 2'd1) rd = {m_status, 2'b00};
    start = !busy && ((m_auto && frame_start) || m_trig);
    tset  = reg_wr && reg_addr == 2'd0 && reg_wdata[1] && !reg_wdata[0] && !busy;
    if (busy) begin
      if (m_cnt == SENSE-1) begin
        m_status = cmp_match & dac_en;
        m_cnt = -1;
      end else m_cnt++;
    end else if (start) m_cnt = 0;
    if (tset) m_trig = 1;
    else if (start) m_trig = 0;
    if (reg_wr && reg_addr == 2'd0) m_auto = reg_wdata[0];
    m_rdata  = rd;
    m_strobe = (m_cnt >= 0);
  endtask

  task automatic compare();
    n_checks++;
    if (sense_strobe !== m_strobe) begin
      n_errors++;
      $display("FAIL %s sense_strobe actual=%0b expected=%0b t=%0t", phase, sense_strobe, m_strobe, $time);
    end
    n_checks++;
    if (reg_rdata !== m_rdata) begin
      n_errors++;
      $display("FAIL %s reg_rdata actual=%02h expected=%02h t=%0t", phase, reg_rdata, m_rdata, $time);
    end
  endtask

  // one clock: inputs already set; model advances at posedge, compare at negedge
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    reg_wr = 0; frame_start = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr_ctrl(input bit [7:0] d);
    reg_wr = 1; reg_addr = 2'd0; reg_wdata = d;
    step();
  endtask

  initial begin
    rst = 1; reg_wr = 0; reg_addr = 0; reg_wdata = 0; frame_start = 0;
    dac_en = '1; cmp_match = '0;
    @(negedge clk);
    idle(3);
    rst = 0;
    // R1: reset state on both addresses
    phase = "R1";
    idle(2); reg_addr = 2'd1; idle(2);
    // R2: auto bit write and readback
    phase = "R2";
    reg_addr = 2'd0; wr_ctrl(8'h01); idle(2); wr_ctrl(8'h00); idle(2);
    // R4: frame_start ignored in manual mode, then one manual check
    phase = "R4";
    frame_start = 1; step(); idle(6);
    cmp_match = 6'b101101;
    wr_ctrl(8'h02);
    phase = "R5"; idle(2);
    phase = "R6"; idle(4);
    phase = "R7"; reg_addr = 2'd1; idle(3);
    // R8: disabled DACs report 0
    phase = "R8";
    dac_en = 6'b110011; cmp_match = 6'b111111;
    wr_ctrl(8'h02); reg_addr = 2'd1; idle(8);
    dac_en = '1;
    // R9: trigger and frame_start during a running check are absorbed
    phase = "R9";
    cmp_match = 6'b010101;
    wr_ctrl(8'h02); reg_addr = 2'd0; idle(1);
    wr_ctrl(8'h02); frame_start = 1; step(); idle(8);
    // R10: status holds, writes to status ignored, comparator changes ignored
    phase = "R10";
    reg_addr = 2'd1; cmp_match = 6'b111000; idle(3);
    reg_wr = 1; reg_addr = 2'd1; reg_wdata = 8'hFF; step(); idle(3);
    // R3: automatic mode, one check per frame
    phase = "R3";
    wr_ctrl(8'h01); reg_addr = 2'd1;
    for (int f = 0; f < 4; f++) begin
      cmp_match = 6'(f * 13 + 7);
      frame_start = 1; step(); idle(9);
    end
    frame_start = 1; step(); frame_start = 1; step(); idle(8);
    // R11: unmapped addresses read as 0
    phase = "R11";
    reg_addr = 2'd2; idle(2); reg_addr = 2'd3; idle(2);
    // mixed stimulus
    phase = "R7";
    for (int i = 0; i < 600; i++) begin
      reg_addr    = 2'($urandom_range(0, 3));
      reg_wr      = ($urandom_range(0, 9) == 0);
      reg_wdata   = 8'($urandom);
      frame_start = ($urandom_range(0, 11) == 0);
      dac_en      = 6'($urandom);
      cmp_match   = 6'($urandom);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule